// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from on-chip peripherals, one line per source, and drives a single request to the host processor on one of eight selectable priority lines. Each source can be enabled or blocked on its own. The block keeps an in-service set so that a source being handled holds off every source of equal or lower rank until software retires it.

Software fetches the winning source with a two-step handshake. It first writes the acknowledge bit of the vector register. This latches the best pending unmasked source and marks that source as in service. Software then reads the vector register to get the source number. A request can vanish or be masked after the host has seen the interrupt line but before the acknowledge lands. In that case the block hands back vector 0, the reserved error vector, and leaves the in-service set unchanged. Software treats vector 0 as a spurious event.

The ranking puts higher source numbers first by default. One source chosen by software can be raised above all others. Software can also rearrange the order of four serial-channel sources among themselves, inside their own span of ranks.

Top module: `vic_top`

## Requirements
- R1: After reset the mask register reads 0, the in-service register reads 0, the vector register reads 0, the configuration register reads 0x1C80 (global enable clear, level 0, serial slots in identity order, no promoted source) and every bit of hostIrq is 0.
- R2: Mask register (address 1) bit n set enables source n. A pending source whose mask bit is clear never wins an acknowledge and never drives hostIrq.
- R3: Configuration bit 16 is the global enable. While it is 0, hostIrq stays all zero. Acknowledges still resolve normally.
- R4: Configuration bits 15:13 give the host level L. When an eligible source exists and the enable is set, exactly hostIrq[L] is 1.
- R5: Writing address 3 with data bit 0 = 1 latches the winning source. A following read of address 3 returns the source number in bits 15:11, with all other bits 0. The winner's in-service bit is set. A write to address 3 with bit 0 = 0 changes nothing.
- R6: With no promotion and identity serial order, a higher source number outranks a lower one.
- R7: Configuration bits 4:0, when nonzero, name a source that outranks all others. The value 0 promotes nothing.
- R8: Sources 28..31 are serial channels 0..3. Configuration bits [6+2p:5+2p] name the channel placed at group rank p, for p = 0..3 with 3 the highest. The placed channel takes the rank of source 28+p. The four fields must form a permutation.
- R9: A source is eligible only if it ranks strictly above every source currently in service.
- R10: Writing address 2 clears each in-service bit written as 1. Bits written as 0 are unchanged.
- R11: An acknowledge with no eligible source returns vector 0 and leaves the in-service register unchanged. This includes a request that drops in the same cycle as the acknowledge write, and a source masked before the acknowledge.
- R12: Source 0 is reserved. Its request line never wins and never drives hostIrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 32 | Level request per source |
| hostAddr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| hostWrEn | input | 1 | Register write strobe |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data for hostAddr (combinational) |
| hostIrq | output | 8 | One-hot host interrupt level |

## Verification
The collision that matters is an acknowledge write arriving in the same clock cycle as a request withdrawal. The acknowledge samples the request lines at the very edge where the source lets go. The bench provokes this by changing srcReq and raising the acknowledge write at the same falling edge, after confirming that hostIrq was asserted. It judges the result by reading back vector 0 and an unchanged in-service register. The masked-before-acknowledge variant and nested acknowledges are checked the same way, through register reads.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_ISR  = 2'd2;
  localparam logic [1:0] ADDR_VEC  = 2'd3;

  // configuration layout
  localparam int CFG_W        = 17;
  localparam int CFG_EN_BIT   = 16;
  localparam int CFG_LVL_LSB  = 13;
  localparam int CFG_SLOT_LSB = 5;
  localparam int SER_CNT      = 4;
  localparam int SLOT_W       = 2 * SER_CNT;

  // vector field sits at the top of the low half-word
  localparam int VEC_TOP = 15;

  typedef struct packed {
    logic cfgWr;
    logic maskWr;
    logic isrClr;
    logic ack;
  } vic_strobe_t;

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic        hostWrEn,
  input  logic [1:0]  hostAddr,
  input  logic        ackBit,
  output vic_strobe_t strobe
);

  always_comb begin
    strobe        = '0;
    strobe.cfgWr  = hostWrEn && (hostAddr == ADDR_CFG);
    strobe.maskWr = hostWrEn && (hostAddr == ADDR_MASK);
    strobe.isrClr = hostWrEn && (hostAddr == ADDR_ISR);
    strobe.ack    = hostWrEn && (hostAddr == ADDR_VEC) && ackBit;
  end

endmodule

// File: rtl/vic_rank.sv
module vic_rank
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int SER_BASE = 28,
  localparam int VEC_W   = $clog2(NUM_SRC),
  localparam int KEY_W   = VEC_W + 1
) (
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] maskQ,
  input  logic [NUM_SRC-1:0] isrQ,
  input  logic [VEC_W-1:0]   cfgPromote,
  input  logic [SLOT_W-1:0]  cfgSlots,
  output logic               winValid,
  output logic [VEC_W-1:0]   winVec
);

  logic [KEY_W-1:0] keyArr [NUM_SRC];
  logic [KEY_W-1:0] maxIsKey;
  logic             anyIs;
  logic [KEY_W-1:0] bestKey;

  // rank key per source: plain number, serial remap, then promotion
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
    if (i >= SER_BASE && i < SER_BASE + SER_CNT) begin : g_ser
      localparam int CH = i - SER_BASE;
      always_comb begin
        keyArr[i] = KEY_W'(i);
        for (int p = 0; p < SER_CNT; p++) begin
          if (cfgSlots[2*p +: 2] == 2'(CH)) keyArr[i] = KEY_W'(SER_BASE + p);
        end
        if (cfgPromote == VEC_W'(i)) keyArr[i] = '1;
      end
    end else begin : g_plain
      always_comb begin
        keyArr[i] = KEY_W'(i);
        if (i != 0 && cfgPromote == VEC_W'(i)) keyArr[i] = '1;
      end
    end
  end

  always_comb begin
    anyIs    = 1'b0;
    maxIsKey = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (isrQ[i] && (!anyIs || keyArr[i] > maxIsKey)) begin
        anyIs    = 1'b1;
        maxIsKey = keyArr[i];
      end
    end

    winValid = 1'b0;
    winVec   = '0;
    bestKey  = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (srcReq[i] && maskQ[i] && (!anyIs || keyArr[i] > maxIsKey) &&
          (!winValid || keyArr[i] > bestKey)) begin
        winValid = 1'b1;
        winVec   = VEC_W'(i);
        bestKey  = keyArr[i];
      end
    end
  end

endmodule

// File: rtl/vic_dp.sv
module vic_dp
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int SER_BASE = 28,
  parameter int NUM_LVL  = 8,
  localparam int VEC_W   = $clog2(NUM_SRC),
  localparam int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  vic_strobe_t        strobe,
  input  logic [31:0]        wdata,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic [CFG_W-1:0]   cfgQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] isrQ,
  output logic [VEC_W-1:0]   vecQ,
  output logic               winValid,
  output logic [VEC_W-1:0]   winVec,
  output logic [NUM_LVL-1:0] hostIrq
);

  localparam logic [SLOT_W-1:0] SLOT_RST = 8'b11_10_01_00;
  localparam logic [CFG_W-1:0]  CFG_RST  = CFG_W'(SLOT_RST) << CFG_SLOT_LSB;

  logic [LVL_W-1:0] cfgLvl;
  assign cfgLvl = cfgQ[CFG_LVL_LSB +: LVL_W];

  vic_rank #(.NUM_SRC(NUM_SRC), .SER_BASE(SER_BASE)) uRank (
    .srcReq    (srcReq),
    .maskQ     (maskQ),
    .isrQ      (isrQ),
    .cfgPromote(cfgQ[VEC_W-1:0]),
    .cfgSlots  (cfgQ[CFG_SLOT_LSB +: SLOT_W]),
    .winValid  (winValid),
    .winVec    (winVec)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= CFG_RST;
      maskQ <= '0;
      isrQ  <= '0;
      vecQ  <= '0;
    end else begin
      if (strobe.cfgWr)  cfgQ  <= wdata[CFG_W-1:0];
      if (strobe.maskWr) maskQ <= wdata[NUM_SRC-1:0];
      if (strobe.isrClr) isrQ  <= isrQ & ~wdata[NUM_SRC-1:0];
      if (strobe.ack) begin
        vecQ <= winValid ? winVec : '0;
        if (winValid) isrQ[winVec] <= 1'b1;
      end
    end
  end

  always_comb begin
    hostIrq = '0;
    if (cfgQ[CFG_EN_BIT] && winValid) hostIrq[cfgLvl] = 1'b1;
  end

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int SER_BASE = 28,
  parameter int NUM_LVL  = 8,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [1:0]         hostAddr,
  input  logic               hostWrEn,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata,
  output logic [NUM_LVL-1:0] hostIrq
);

  vic_strobe_t        strobe;
  logic [CFG_W-1:0]   cfgQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] isrQ;
  logic [VEC_W-1:0]   vecQ;
  logic               winValid;
  logic [VEC_W-1:0]   winVec;

  vic_ctrl uCtrl (
    .hostWrEn(hostWrEn),
    .hostAddr(hostAddr),
    .ackBit  (hostWdata[0]),
    .strobe  (strobe)
  );

  vic_dp #(.NUM_SRC(NUM_SRC), .SER_BASE(SER_BASE), .NUM_LVL(NUM_LVL)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdata   (hostWdata),
    .srcReq  (srcReq),
    .cfgQ    (cfgQ),
    .maskQ   (maskQ),
    .isrQ    (isrQ),
    .vecQ    (vecQ),
    .winValid(winValid),
    .winVec  (winVec),
    .hostIrq (hostIrq)
  );

  always_comb begin
    unique case (hostAddr)
      ADDR_CFG:  hostRdata = 32'(cfgQ);
      ADDR_MASK: hostRdata = 32'(maskQ);
      ADDR_ISR:  hostRdata = 32'(isrQ);
      default:   hostRdata = 32'(vecQ) << (VEC_TOP + 1 - VEC_W);
    endcase
  end

endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 8,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               ackEv,
  input logic               cfgEn,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] isrQ,
  input logic [VEC_W-1:0]   vecQ,
  input logic               winValid,
  input logic [VEC_W-1:0]   winVec,
  input logic [NUM_LVL-1:0] hostIrq
);

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hostIrq)); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |-> hostIrq == '0); // R3

  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> maskQ[winVec]); // R2

  AST_SRC0_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> winVec != '0); // R12

  AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> !isrQ[winVec]); // R9

  AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ackEv && winValid |=> vecQ == $past(winVec) && isrQ[vecQ]); // R5

  AST_ERR_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    ackEv && !winValid |=> vecQ == '0 && $stable(isrQ)); // R11

  AST_ISR_SET_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !ackEv |=> (isrQ & ~$past(isrQ)) == '0); // R10

endmodule

bind vic_top vic_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .ackEv   (strobe.ack),
  .cfgEn   (cfgQ[vic_pkg::CFG_EN_BIT]),
  .maskQ   (maskQ),
  .isrQ    (isrQ),
  .vecQ    (vecQ),
  .winValid(winValid),
  .winVec  (winVec),
  .hostIrq (hostIrq)
);

// File: tb/vic_top_test.sv
module vic_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcReq = '0;
  logic [1:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [7:0]  hostIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vic_top uut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .hostAddr(hostAddr),
    .hostWrEn(hostWrEn), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostIrq(hostIrq)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [31:0] mask;
    logic [31:0] cfg;
    logic [4:0]  vec;
    logic [7:0]  irq;
  } vec_t;

  localparam vec_t TABLE [8] = '{
    '{32'h0000_0006, 32'hFFFF_FFFF, 32'h0001_1C80, 5'd2,  8'h01}, // R6
    '{32'h8000_0001, 32'hFFFF_FFFF, 32'h0001_1C80, 5'd31, 8'h01}, // R6
    '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0001_1C80, 5'd0,  8'h00}, // R12
    '{32'h0000_0300, 32'h0000_0100, 32'h0001_1C80, 5'd8,  8'h01}, // R2
    '{32'h8000_0020, 32'hFFFF_FFFF, 32'h0001_1C85, 5'd5,  8'h01}, // R7
    '{32'h9000_0000, 32'hFFFF_FFFF, 32'h0001_0360, 5'd28, 8'h01}, // R8
    '{32'h0000_0010, 32'hFFFF_FFFF, 32'h0001_BC80, 5'd4,  8'h20}, // R4
    '{32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_1C80, 5'd4,  8'h00}  // R3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    hostAddr = a;
    #1;
    check(hostRdata == exp, req, hostRdata, exp);
  endtask

  task automatic setReq(input logic [31:0] r);
    @(negedge clk);
    srcReq = r;
    #1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdCheck(2'd0, 32'h0000_1C80, "R1 cfg");
    rdCheck(2'd1, 32'h0, "R1 mask");
    rdCheck(2'd2, 32'h0, "R1 isr");
    rdCheck(2'd3, 32'h0, "R1 vec");
    setReq(32'hFFFF_FFFF);
    check(hostIrq == 8'h00, "R1 irq", 32'(hostIrq), 32'h0);
    setReq(32'h0);

    // table walk
    for (int k = 0; k < 8; k++) begin
      wr(2'd0, TABLE[k].cfg);
      wr(2'd1, TABLE[k].mask);
      setReq(TABLE[k].req);
      check(hostIrq == TABLE[k].irq, "R2/R3/R4 irq", 32'(hostIrq), 32'(TABLE[k].irq));
      wr(2'd3, 32'h1);
      rdCheck(2'd3, 32'(TABLE[k].vec) << 11, "R5/R6/R7/R8 vec");
      rdCheck(2'd2, (TABLE[k].vec != 0) ? (32'h1 << TABLE[k].vec) : 32'h0, "R5 isr");
      setReq(32'h0);
      wr(2'd2, 32'hFFFF_FFFF);
    end

    // R11: request dropped in the same cycle as the acknowledge
    wr(2'd0, 32'h0001_1C80);
    wr(2'd1, 32'hFFFF_FFFF);
    setReq(32'h80);
    check(hostIrq == 8'h01, "R11 pre irq", 32'(hostIrq), 32'h1);
    @(negedge clk);
    hostAddr = 2'd3; hostWdata = 32'h1; hostWrEn = 1'b1; srcReq = 32'h0;
    @(negedge clk);
    hostWrEn = 1'b0;
    rdCheck(2'd3, 32'h0, "R11 race vec");
    rdCheck(2'd2, 32'h0, "R11 race isr");

    // R11: masked before acknowledge
    setReq(32'h80);
    wr(2'd1, 32'h0);
    check(hostIrq == 8'h00, "R2 masked irq", 32'(hostIrq), 32'h0);
    wr(2'd3, 32'h1);
    rdCheck(2'd3, 32'h0, "R11 masked vec");
    rdCheck(2'd2, 32'h0, "R11 masked isr");

    // R5: write with acknowledge bit clear changes nothing
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd3, 32'h1);
    rdCheck(2'd3, 32'd7 << 11, "R5 vec 7");
    wr(2'd2, 32'hFFFF_FFFF);
    setReq(32'h200);
    wr(2'd3, 32'h0);
    rdCheck(2'd3, 32'd7 << 11, "R5 no-ack vec");
    rdCheck(2'd2, 32'h0, "R5 no-ack isr");

    // R9 nesting
    setReq(32'h400);
    wr(2'd3, 32'h1);
    rdCheck(2'd3, 32'd10 << 11, "R9 first vec");
    setReq(32'h420);
    check(hostIrq == 8'h00, "R9 lower blocked", 32'(hostIrq), 32'h0);
    setReq(32'h1420);
    check(hostIrq == 8'h01, "R9 higher passes", 32'(hostIrq), 32'h1);
    wr(2'd3, 32'h1);
    rdCheck(2'd3, 32'd12 << 11, "R9 nested vec");
    rdCheck(2'd2, 32'h1400, "R9 nested isr");

    // R10 write-one-to-clear
    wr(2'd2, 32'h0);
    rdCheck(2'd2, 32'h1400, "R10 zero write");
    wr(2'd2, 32'h1000);
    rdCheck(2'd2, 32'h0400, "R10 one write");
    wr(2'd2, 32'hFFFF_FFFF);
    rdCheck(2'd2, 32'h0, "R10 all clear");

    finishRun();
  end

endmodule